// File: doc/BRIEF.md
# Run-Time Coefficient Update Sequencer

This block lets a host change coefficient RAM words while the signal-processing engine keeps running. The host loads a staging buffer of 1 to 16 address/data entries through a byte-wide command stream. It can read the buffer back to confirm it, then issues an execute command. The block never writes on the host's timing. It watches the engine's current RAM access address and commits a staged word only in the cycle that address equals the word's target. Words are committed strictly in the order they were staged.

The host sees one command byte (`host_cmd_valid`), the bytes that follow it (`host_byte_valid`) and a pull strobe for readback words. The engine side supplies its access address every cycle, a sample strobe and a run flag. The block drives a single RAM write port. The `ready` output tells the host when it may issue commands again. The `err` flag records commands that were refused.

Top module: `cram_update_seq`

## Requirements
- R1: After reset `ready` is 1, and `ram_we`, `err` and `host_rd_valid` are 0.
- R2: Command byte 0x80+(n-1), for n from 1 to 16, opens a preparation of n entries. It is followed by a 2-byte start field and then, per entry, 2 address bytes and 3 data bytes, each field most significant byte first.
- R3: Command 0x24 rewinds readback. Each `host_rd_req` pulse returns one word on `host_rd_data` with `host_rd_valid` high in the next cycle. The words run in the order entry address (zero-extended), entry data, for each loaded entry. Any request past the loaded entries returns 0x000001.
- R4: Execute is command 0xA4 followed by two zero bytes. In the cycle after the second byte is accepted, `ready` is 0, and it stays 0 until the last staged word has been written.
- R5: A staged word is written (`ram_we`=1, `ram_waddr`, `ram_wdata`) only in a cycle where `eng_addr` equals that word's address. The write is combinational in that same cycle.
- R6: Words are written in staged order. While an earlier word is pending, a later word's address on `eng_addr` causes no write, and that word waits for a later pass.
- R7: An execute without a valid, completed preparation is ignored: no RAM write and `ready` stays 1, and `err` is set. This covers execute with no preparation, after an interrupted preparation, and a second execute of an already executed buffer.
- R8: A preparation command is rejected and sets `err` while `dsp_run` is 0, or before two `fs_tick` pulses have been seen since `dsp_run` rose. A rejected preparation leaves the buffer unchanged.
- R9: An accepted preparation command discards any staged content not yet executed, so a later readback returns only the newly loaded entries.
- R10: `err` is sticky and clears only when a preparation completes with an all-zero start field. Any command issued while `ready` is 0 is ignored and sets `err`.
- R11: A preparation whose start field is not all zero loads its entries but is not valid for execution, and sets `err` when its last entry arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dsp_run | input | 1 | Engine running; low holds the engine in reset |
| fs_tick | input | 1 | One-cycle pulse per sample period |
| host_cmd_valid | input | 1 | A command byte is present |
| host_cmd | input | 8 | Command byte |
| host_byte_valid | input | 1 | A parameter byte is present |
| host_byte | input | 8 | Parameter byte |
| host_rd_req | input | 1 | Pull the next readback word |
| host_rd_valid | output | 1 | Readback word is valid |
| host_rd_data | output | DATA_W | Readback word |
| eng_addr | input | ADDR_W | Engine's current RAM access address |
| ram_we | output | 1 | RAM write enable |
| ram_waddr | output | ADDR_W | RAM write address |
| ram_wdata | output | DATA_W | RAM write data |
| ready | output | 1 | Host may issue commands |
| err | output | 1 | Sticky refused-command flag |

## Verification
Commits are tried with an engine address pattern that jumps and revisits: a window of five consecutive targets is driven with addresses that skip one target and return to it. This separates a design that commits on any address match from one that commits only the pending head. A free sweeping engine with targets staged in falling address order forces one commit per sweep and confirms that waiting words survive wrap-around. Full 16-entry buffers and single-entry buffers exercise the count decode at both ends. Execute after no preparation, after an interrupted preparation, after a bad start field and after consumption each show whether the commit path can be entered without a valid buffer.

// File: rtl/cram_upd_pkg.sv
package cram_upd_pkg;

  typedef enum logic [1:0] {
    PS_IDLE  = 2'd0,
    PS_START = 2'd1,
    PS_ENTRY = 2'd2,
    PS_EXEC  = 2'd3
  } parse_state_e;

  // number of entries selected by a preparation code (low nibble + 1)
  function automatic logic [4:0] prep_len(input logic [7:0] code);
    return {1'b0, code[3:0]} + 5'd1;
  endfunction

  // preparation codes share their upper nibble with the base code
  function automatic logic is_prep_code(input logic [7:0] code, input logic [7:0] base);
    return code[7:4] == base[7:4];
  endfunction

  // readback slot: even slot = address, odd slot = data, past the end = fill value 1
  function automatic logic [63:0] rb_slot(input logic in_range, input logic odd,
                                           input logic [63:0] addr_ext,
                                           input logic [63:0] data_ext);
    if (!in_range) return 64'd1;
    return odd ? data_ext : addr_ext;
  endfunction

endpackage

// File: rtl/cram_cmd_parser.sv
module cram_cmd_parser
  import cram_upd_pkg::*;
#(
  parameter int          ADDR_W        = 16,
  parameter int          DATA_W        = 24,
  parameter int          DEPTH         = 16,
  parameter logic [7:0]  CMD_PREP_BASE = 8'h80,
  parameter logic [7:0]  CMD_READ      = 8'h24,
  parameter logic [7:0]  CMD_EXEC      = 8'hA4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic [7:0]                    cmd_code,
  input  logic                          byte_valid,
  input  logic [7:0]                    byte_data,
  input  logic                          busy,
  input  logic                          gate_ok,
  output logic                          ent_we,
  output logic [$clog2(DEPTH)-1:0]      ent_idx,
  output logic [ADDR_W-1:0]             ent_addr,
  output logic [DATA_W-1:0]             ent_data,
  output logic                          stage_clr,
  output logic                          exec_go,
  output logic                          rb_restart,
  output logic                          err
);
  localparam int ADDR_BYTES = (ADDR_W + 7) / 8;
  localparam int DATA_BYTES = (DATA_W + 7) / 8;
  localparam int ENT_BYTES  = ADDR_BYTES + DATA_BYTES;
  localparam int ENT_BITS   = ENT_BYTES * 8;
  localparam int IDX_W      = $clog2(DEPTH);
  localparam int CNT_W      = $clog2(DEPTH + 1);
  localparam int BC_W       = $clog2(ENT_BYTES + 1);

  parse_state_e          state;
  logic [CNT_W-1:0]      need;
  logic [IDX_W-1:0]      idx;
  logic [BC_W-1:0]       bcnt;
  logic [ENT_BITS-9:0]   sh;
  logic                  bad;
  logic                  prep_ok;

  logic                  cmd_take, cmd_blocked, prep_cmd, prep_accept, prep_reject;
  logic                  exec_cmd, byte_in, exec_fire, exec_bad, prep_done;
  logic [4:0]            len;
  logic [ENT_BITS-1:0]   entry_word;

  always_comb begin
    cmd_take    = cmd_valid && !busy;
    cmd_blocked = cmd_valid && busy;
    len         = prep_len(cmd_code);
    prep_cmd    = cmd_take && is_prep_code(cmd_code, CMD_PREP_BASE);
    prep_accept = prep_cmd && gate_ok && (int'(len) <= DEPTH);
    prep_reject = prep_cmd && !prep_accept;
    exec_cmd    = cmd_take && (cmd_code == CMD_EXEC);
    rb_restart  = cmd_take && (cmd_code == CMD_READ);
    byte_in     = byte_valid && !cmd_valid && !busy;
    entry_word  = {sh, byte_data};
    ent_addr    = entry_word[DATA_BYTES*8 +: ADDR_W];
    ent_data    = entry_word[DATA_W-1:0];
    ent_idx     = idx;
    ent_we      = byte_in && (state == PS_ENTRY) && (int'(bcnt) == ENT_BYTES - 1);
    prep_done   = ent_we && ((CNT_W'(idx) + CNT_W'(1)) == need);
    exec_fire   = byte_in && (state == PS_EXEC) && (bcnt == BC_W'(1));
    exec_go     = exec_fire && prep_ok && !bad && (byte_data == 8'h00);
    exec_bad    = exec_fire && !exec_go;
    stage_clr   = prep_accept;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PS_IDLE;
      need    <= '0;
      idx     <= '0;
      bcnt    <= '0;
      sh      <= '0;
      bad     <= 1'b0;
      prep_ok <= 1'b0;
      err     <= 1'b0;
    end else begin
      if (cmd_take) begin
        bcnt <= '0;
        idx  <= '0;
        bad  <= 1'b0;
        if (prep_accept) begin
          state   <= PS_START;
          need    <= CNT_W'(len);
          prep_ok <= 1'b0;
        end else if (exec_cmd) begin
          state <= PS_EXEC;
        end else begin
          state <= PS_IDLE;
        end
      end else if (byte_in) begin
        unique case (state)
          PS_START: begin
            if (byte_data != 8'h00) bad <= 1'b1;
            if (bcnt == BC_W'(1)) begin
              state <= PS_ENTRY;
              bcnt  <= '0;
            end else begin
              bcnt <= bcnt + BC_W'(1);
            end
          end
          PS_ENTRY: begin
            sh <= entry_word[ENT_BITS-9:0];
            if (ent_we) begin
              bcnt <= '0;
              idx  <= idx + IDX_W'(1);
              if (prep_done) begin
                state   <= PS_IDLE;
                prep_ok <= !bad;
              end
            end else begin
              bcnt <= bcnt + BC_W'(1);
            end
          end
          PS_EXEC: begin
            if (byte_data != 8'h00) bad <= 1'b1;
            if (exec_fire) begin
              state <= PS_IDLE;
              if (exec_go) prep_ok <= 1'b0;
            end else begin
              bcnt <= bcnt + BC_W'(1);
            end
          end
          default: ;
        endcase
      end

      if (cmd_blocked || prep_reject || exec_bad || (prep_done && bad))
        err <= 1'b1;
      else if (prep_done && !bad)
        err <= 1'b0;
    end
  end

  // a refused preparation is always visible on the flag
  assert_reject_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    prep_reject |=> err);

  // a command while busy is never silently dropped
  assert_busy_cmd_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_blocked |=> err);

  // no entry beyond the count chosen by the command code
  assert_entry_in_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ent_we |-> (CNT_W'(idx) < need));

endmodule

// File: rtl/cram_stage_buf.sv
module cram_stage_buf
  import cram_upd_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 24,
  parameter int DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          clr,
  input  logic                          we,
  input  logic [$clog2(DEPTH)-1:0]      widx,
  input  logic [ADDR_W-1:0]             waddr,
  input  logic [DATA_W-1:0]             wdata,
  input  logic [$clog2(DEPTH)-1:0]      head_idx,
  output logic [ADDR_W-1:0]             head_addr,
  output logic [DATA_W-1:0]             head_data,
  output logic [$clog2(DEPTH+1)-1:0]    ld_cnt,
  input  logic                          rb_restart,
  input  logic                          rd_req,
  output logic                          rd_valid,
  output logic [DATA_W-1:0]             rd_data
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int RB_W  = $clog2(2 * DEPTH + 1);

  logic [ADDR_W-1:0] addr_mem [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];
  logic [RB_W-1:0]   rb_ptr;
  logic [RB_W-2:0]   rb_ent;
  logic              rb_in;
  logic [63:0]       rb_word;

  always_ff @(posedge clk) begin
    if (we) begin
      addr_mem[widx] <= waddr;
      data_mem[widx] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   ld_cnt <= '0;
    else if (clr) ld_cnt <= '0;
    else if (we)  ld_cnt <= ld_cnt + CNT_W'(1);
  end

  assign head_addr = addr_mem[head_idx];
  assign head_data = data_mem[head_idx];

  always_comb begin
    rb_ent  = rb_ptr[RB_W-1:1];
    rb_in   = (int'(rb_ent) < int'(ld_cnt));
    rb_word = rb_slot(rb_in, rb_ptr[0],
                      64'(addr_mem[rb_ent[IDX_W-1:0]]),
                      64'(data_mem[rb_ent[IDX_W-1:0]]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rb_ptr   <= '0;
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_req;
      if (rb_restart) begin
        rb_ptr <= '0;
      end else if (rd_req) begin
        rd_data <= rb_word[DATA_W-1:0];
        if (int'(rb_ptr) < 2 * DEPTH) rb_ptr <= rb_ptr + RB_W'(1);
      end
    end
  end

  // loaded count never exceeds the buffer depth
  assert_count_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |-> (int'(ld_cnt) < DEPTH));

endmodule

// File: rtl/cram_commit_seq.sv
module cram_commit_seq #(
  parameter int ADDR_W = 16,
  parameter int DEPTH  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          exec_go,
  input  logic [$clog2(DEPTH+1)-1:0]    total,
  input  logic [ADDR_W-1:0]             eng_addr,
  input  logic [ADDR_W-1:0]             head_addr,
  output logic [$clog2(DEPTH)-1:0]      head_idx,
  output logic                          busy,
  output logic                          hit
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [CNT_W-1:0] tot;
  logic             last;

  always_comb begin
    hit  = busy && (eng_addr == head_addr);
    last = (CNT_W'(head_idx) + CNT_W'(1)) == tot;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      head_idx <= '0;
      tot      <= '0;
    end else if (exec_go) begin
      busy     <= 1'b1;
      head_idx <= '0;
      tot      <= total;
    end else if (hit) begin
      if (last) busy     <= 1'b0;
      else      head_idx <= head_idx + IDX_W'(1);
    end
  end

  // a commit moves the head by exactly one, or ends the run
  assert_head_steps_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !exec_go) |=> (!busy || (head_idx == $past(head_idx) + IDX_W'(1))));

  // the head never leaves the staged range while running
  assert_head_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (CNT_W'(head_idx) < tot));

  // without a match the head holds still
  assert_head_waits_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !hit && !exec_go) |=> $stable(head_idx) && busy);

endmodule

// File: rtl/cram_update_seq.sv
module cram_update_seq #(
  parameter int          ADDR_W        = 16,
  parameter int          DATA_W        = 24,
  parameter int          DEPTH         = 16,
  parameter int          GATE_TICKS    = 2,
  parameter logic [7:0]  CMD_PREP_BASE = 8'h80,
  parameter logic [7:0]  CMD_READ      = 8'h24,
  parameter logic [7:0]  CMD_EXEC      = 8'hA4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dsp_run,
  input  logic              fs_tick,
  input  logic              host_cmd_valid,
  input  logic [7:0]        host_cmd,
  input  logic              host_byte_valid,
  input  logic [7:0]        host_byte,
  input  logic              host_rd_req,
  output logic              host_rd_valid,
  output logic [DATA_W-1:0] host_rd_data,
  input  logic [ADDR_W-1:0] eng_addr,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_waddr,
  output logic [DATA_W-1:0] ram_wdata,
  output logic              ready,
  output logic              err
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int GT_W  = $clog2(GATE_TICKS + 1);

  // named internal events
  logic              gate_ok;
  logic [GT_W-1:0]   gate_cnt;
  logic              ent_we, stage_clr, exec_go, rb_restart, busy, hit;
  logic [IDX_W-1:0]  ent_idx, head_idx;
  logic [ADDR_W-1:0] ent_addr, head_addr;
  logic [DATA_W-1:0] ent_data, head_data;
  logic [CNT_W-1:0]  ld_cnt;

  // sample periods seen since the engine left reset
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                    gate_cnt <= '0;
    else if (!dsp_run)                             gate_cnt <= '0;
    else if (fs_tick && int'(gate_cnt) < GATE_TICKS) gate_cnt <= gate_cnt + GT_W'(1);
  end
  assign gate_ok = dsp_run && (int'(gate_cnt) == GATE_TICKS);

  cram_cmd_parser #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH),
    .CMD_PREP_BASE(CMD_PREP_BASE), .CMD_READ(CMD_READ), .CMD_EXEC(CMD_EXEC)
  ) u_parse (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(host_cmd_valid), .cmd_code(host_cmd),
    .byte_valid(host_byte_valid), .byte_data(host_byte),
    .busy(busy), .gate_ok(gate_ok),
    .ent_we(ent_we), .ent_idx(ent_idx), .ent_addr(ent_addr), .ent_data(ent_data),
    .stage_clr(stage_clr), .exec_go(exec_go), .rb_restart(rb_restart), .err(err)
  );

  cram_stage_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .clr(stage_clr), .we(ent_we), .widx(ent_idx), .waddr(ent_addr), .wdata(ent_data),
    .head_idx(head_idx), .head_addr(head_addr), .head_data(head_data), .ld_cnt(ld_cnt),
    .rb_restart(rb_restart), .rd_req(host_rd_req),
    .rd_valid(host_rd_valid), .rd_data(host_rd_data)
  );

  cram_commit_seq #(.ADDR_W(ADDR_W), .DEPTH(DEPTH)) u_commit (
    .clk(clk), .rst_n(rst_n),
    .exec_go(exec_go), .total(ld_cnt), .eng_addr(eng_addr), .head_addr(head_addr),
    .head_idx(head_idx), .busy(busy), .hit(hit)
  );

  assign ram_we    = hit;
  assign ram_waddr = head_addr;
  assign ram_wdata = head_data;
  assign ready     = !busy;

  // an accepted execute drops ready at once
  assert_exec_drops_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !ready);

  // execution only starts on a non-empty buffer
  assert_exec_has_data_R7: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> (ld_cnt != '0));

  // the gate is closed right after the engine leaves reset
  assert_gate_closed_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dsp_run) |=> !gate_ok);

  // the RAM is written only at the engine's current address
  assert_write_at_engine_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (ram_waddr == eng_addr) && !ready);

endmodule

// File: tb/cram_update_seq_test.sv
module cram_update_seq_test;
  localparam int ENG_TOP = 31;
  localparam int PARK    = 40;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        dsp_run = 1'b0;
  logic        fs_tick = 1'b0;
  logic        host_cmd_valid = 1'b0;
  logic [7:0]  host_cmd = '0;
  logic        host_byte_valid = 1'b0;
  logic [7:0]  host_byte = '0;
  logic        host_rd_req = 1'b0;
  logic        host_rd_valid;
  logic [23:0] host_rd_data;
  logic [15:0] eng_addr = 16'(PARK);
  logic        ram_we;
  logic [15:0] ram_waddr;
  logic [23:0] ram_wdata;
  logic        ready, err;

  int n_cmp = 0;
  int n_bad = 0;
  bit sweep_en = 1'b0;
  bit done = 1'b0;

  logic [15:0] st_addr [16];
  logic [23:0] st_data [16];
  logic [39:0] exp_q [$];

  always #10 clk = ~clk;

  cram_update_seq uut (
    .clk(clk), .rst_n(rst_n), .dsp_run(dsp_run), .fs_tick(fs_tick),
    .host_cmd_valid(host_cmd_valid), .host_cmd(host_cmd),
    .host_byte_valid(host_byte_valid), .host_byte(host_byte),
    .host_rd_req(host_rd_req), .host_rd_valid(host_rd_valid), .host_rd_data(host_rd_data),
    .eng_addr(eng_addr), .ram_we(ram_we), .ram_waddr(ram_waddr), .ram_wdata(ram_wdata),
    .ready(ready), .err(err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // engine model: sweeps 0..ENG_TOP, strobe on wrap
  always @(posedge clk) begin
    #1;
    if (sweep_en) begin
      eng_addr = (int'(eng_addr) >= ENG_TOP) ? 16'd0 : eng_addr + 16'd1;
      fs_tick  = (eng_addr == 16'd0);
    end else begin
      fs_tick = 1'b0;
    end
  end

  // scoreboard monitor: every RAM write must match the next expected item
  always @(negedge clk) begin
    if (rst_n && ram_we) begin
      logic [39:0] exp_item;
      chk(ram_waddr == eng_addr, "R5", "write address vs engine address",
          40'(ram_waddr), 40'(eng_addr));
      if (exp_q.size() == 0) begin
        chk(1'b0, "R7", "unexpected RAM write", {ram_waddr, ram_wdata}, 40'h0);
      end else begin
        exp_item = exp_q.pop_front();
        chk({ram_waddr, ram_wdata} == exp_item, "R6", "committed word order",
            {ram_waddr, ram_wdata}, exp_item);
      end
    end
  end

  task automatic send_cmd(input logic [7:0] c);
    @(posedge clk); #1 host_cmd_valid = 1'b1; host_cmd = c;
    @(posedge clk); #1 host_cmd_valid = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(posedge clk); #1 host_byte_valid = 1'b1; host_byte = b;
    @(posedge clk); #1 host_byte_valid = 1'b0;
  endtask

  task automatic do_prep(input int n, input logic [15:0] start_f, input int sent);
    send_cmd(8'(8'h80 + n - 1));
    send_byte(start_f[15:8]);
    send_byte(start_f[7:0]);
    for (int i = 0; i < sent; i++) begin
      send_byte(st_addr[i][15:8]);
      send_byte(st_addr[i][7:0]);
      send_byte(st_data[i][23:16]);
      send_byte(st_data[i][15:8]);
      send_byte(st_data[i][7:0]);
    end
  endtask

  task automatic do_exec();
    send_cmd(8'hA4);
    send_byte(8'h00);
    send_byte(8'h00);
  endtask

  task automatic rd_one(output logic [23:0] w, output logic v);
    @(posedge clk); #1 host_rd_req = 1'b1;
    @(posedge clk); #1 host_rd_req = 1'b0;
    @(negedge clk);
    w = host_rd_data;
    v = host_rd_valid;
  endtask

  task automatic rb_check(input int n);
    logic [23:0] w;
    logic v;
    send_cmd(8'h24);
    for (int i = 0; i < n; i++) begin
      rd_one(w, v);
      chk(v && w == 24'(st_addr[i]), "R3", "readback address", 40'(w), 40'(st_addr[i]));
      rd_one(w, v);
      chk(v && w == st_data[i], "R3", "readback data", 40'(w), 40'(st_data[i]));
    end
    for (int k = 0; k < 2; k++) begin
      rd_one(w, v);
      chk(v && w == 24'h000001, "R3", "readback past end", 40'(w), 40'h1);
    end
  endtask

  task automatic push_exp(input int n);
    for (int i = 0; i < n; i++) exp_q.push_back({st_addr[i], st_data[i]});
  endtask

  task automatic wait_ready(input string req);
    int t = 0;
    @(negedge clk);
    while (!ready && t < 2000) begin
      @(negedge clk);
      t++;
    end
    chk(ready, req, "ready returns after commits", 40'(ready), 40'h1);
    chk(exp_q.size() == 0, req, "all staged words committed", 40'(exp_q.size()), 40'h0);
  endtask

  task automatic idle_check(input int cycles, input string req);
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (!ready) begin
        chk(1'b0, req, "ready stayed high", 40'(ready), 40'h1);
        break;
      end
    end
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "WD", "watchdog expired", 40'h0, 40'h1);
    finish_up();
  end

  // engine address pattern with a revisit, staged targets 10..14
  localparam int SEQ_N = 12;
  int seq_a [SEQ_N] = '{7, 8, 9, 10, 11, 13, 16, 11, 12, 13, 14, 15};
  bit seq_w [SEQ_N] = '{0, 0, 0, 1, 1, 0, 0, 0, 1, 1, 1, 0};

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(ready == 1'b1, "R1", "ready after reset", 40'(ready), 40'h1);
    chk(ram_we == 1'b0, "R1", "write enable after reset", 40'(ram_we), 40'h0);
    chk(err == 1'b0, "R1", "err after reset", 40'(err), 40'h0);
    chk(host_rd_valid == 1'b0, "R1", "readback valid after reset", 40'(host_rd_valid), 40'h0);

    // R8: preparation right after engine leaves reset is refused
    @(posedge clk); #1 dsp_run = 1'b1;
    st_addr[0] = 16'd3; st_data[0] = 24'h123456;
    do_prep(1, 16'h0000, 1);
    @(negedge clk);
    chk(err == 1'b1, "R8", "early preparation refused", 40'(err), 40'h1);
    rb_check(0);

    // open the gate: run the engine for more than two sample periods
    sweep_en = 1'b1;
    repeat (3 * (ENG_TOP + 1)) @(posedge clk);
    sweep_en = 1'b0;
    @(posedge clk); #1 eng_addr = 16'(PARK);

    // R2/R10: five entries at 10..14, valid start field clears err
    for (int i = 0; i < 5; i++) begin
      st_addr[i] = 16'(10 + i);
      st_data[i] = 24'(24'h100000 + i * 24'h001111);
    end
    do_prep(5, 16'h0000, 5);
    @(negedge clk);
    chk(err == 1'b0, "R10", "valid preparation clears err", 40'(err), 40'h1 ^ 40'h1);
    rb_check(5);

    // R4: execute with engine parked away from any target
    push_exp(5);
    do_exec();
    @(negedge clk);
    chk(ready == 1'b0, "R4", "ready low after execute", 40'(ready), 40'h0);
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R4", "ready held low while pending", 40'(ready), 40'h0);

    // R6: revisiting address pattern, write only on the pending head
    for (int k = 0; k < SEQ_N; k++) begin
      @(posedge clk); #1 eng_addr = 16'(seq_a[k]);
      @(negedge clk);
      chk(ram_we == seq_w[k], "R6", $sformatf("write at step %0d", k),
          40'(ram_we), 40'(seq_w[k]));
    end
    chk(ready == 1'b1, "R4", "ready back after last commit", 40'(ready), 40'h1);
    chk(exp_q.size() == 0, "R6", "five words committed", 40'(exp_q.size()), 40'h0);

    // R7: second execute of a consumed buffer is ignored
    do_exec();
    @(negedge clk);
    chk(err == 1'b1, "R7", "execute of consumed buffer flags err", 40'(err), 40'h1);
    chk(ready == 1'b1, "R7", "consumed execute keeps ready", 40'(ready), 40'h1);
    sweep_en = 1'b1;
    idle_check(40, "R7");

    // R9: staged but unexecuted content is replaced by a new preparation
    st_addr[0] = 16'd7; st_data[0] = 24'hDEAD01;
    do_prep(1, 16'h0000, 1);
    st_addr[0] = 16'd20; st_data[0] = 24'hAAAAAA;
    st_addr[1] = 16'd5;  st_data[1] = 24'hBBBBBB;
    do_prep(2, 16'h0000, 2);
    rb_check(2);

    // R6: later target comes first in each sweep, waits for next pass
    push_exp(2);
    do_exec();
    wait_ready("R6");

    // R7: interrupted preparation then execute
    do_prep(2, 16'h0000, 1);
    do_exec();
    @(negedge clk);
    chk(err == 1'b1, "R7", "execute after interrupted preparation", 40'(err), 40'h1);
    idle_check(40, "R7");

    // R11: nonzero start field, then execute ignored
    st_addr[0] = 16'd9; st_data[0] = 24'h0F0F0F;
    do_prep(1, 16'h0000, 1);
    @(negedge clk);
    chk(err == 1'b0, "R10", "err cleared again", 40'(err), 40'h0);
    do_prep(1, 16'h0100, 1);
    @(negedge clk);
    chk(err == 1'b1, "R11", "nonzero start field flags err", 40'(err), 40'h1);
    do_exec();
    idle_check(40, "R11");

    // R2: full sixteen-entry buffer, falling addresses
    for (int i = 0; i < 16; i++) begin
      st_addr[i] = 16'(31 - i);
      st_data[i] = 24'(24'h0A0000 + i * 24'h000105);
    end
    do_prep(16, 16'h0000, 16);
    @(negedge clk);
    chk(err == 1'b0, "R2", "sixteen-entry preparation accepted", 40'(err), 40'h0);
    rb_check(16);
    push_exp(16);
    do_exec();
    // R10: command while busy is refused
    send_cmd(8'h24);
    @(negedge clk);
    chk(ready == 1'b0, "R10", "still busy during refused command", 40'(ready), 40'h0);
    chk(err == 1'b1, "R10", "command while busy flags err", 40'(err), 40'h1);
    wait_ready("R2");

    sweep_en = 1'b0;
    repeat (4) @(posedge clk);
    finish_up();
  end

endmodule